// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block models a parallel NOR flash device as seen from a simple synchronous bus. A byte-wide storage array sits behind a command state machine: bus writes are not stored directly but decoded as command cycles. Those cycles arm a single-word program, clear a whole sector, run a buffered multi-word program, clear the status register, acknowledge a lock or unlock request, or switch reads to the identifier codes or the query table.

Bus reads return array words, the status register, identifier codes or query-table bytes, depending on the command state the device is in. The data width is a parameter of 1, 2 or 4 bytes. A second parameter sets the byte order in which a word is laid across consecutive bytes of storage. Array size, sector size and write-buffer depth are also parameters. The requirements below assume the defaults: a 2-byte word, a 256-byte array, 32-byte sectors, a 16-word buffer, manufacturer code 0x0089 and device code 0x0018. Timing of real program and erase operations is not modelled; every operation completes in the cycle of its bus write.

Top module: `nor_cmd_flash`

## Requirements
- R1: A synchronous active-high reset puts the device in array-read mode, zeroes the status register and sets every array byte to 0xFF. Reads then return 0xFFFF at every word.
- R2: In array-read mode, a read with `rdEn` high returns the word at `addr`, with the address bits below the word size ignored. `rdData` is registered and updates on the clock edge that samples `rdEn`.
- R3: In array-read mode, a write whose low byte is 0x10 or 0x40 arms a program. The next write stores its word at its address, sets status bit 7 and returns to array-read.
- R4: Command 0x20 sets every byte of the sector holding `addr` to 0xFF and sets status bit 7. The next write returns the device to array-read whatever its value, and a value of 0xD0 also sets status bit 7.
- R5: Command 0xE8 sets status bit 7. The next write gives a count N in its low 4 bits, and the N+1 writes after that are stored at their addresses. One more write returns to array-read, setting status bit 7 if it is 0xD0.
- R6: Command 0x50 zeroes the status register and returns to array-read. Commands 0xFF and 0x00 return to array-read with no other effect.
- R7: After command 0x70, reads return the 8-bit status register zero-extended, with bit 7 as the ready flag. A write in this state is decoded as a new command.
- R8: Command 0x60 waits for one more write. A value of 0xD0 or 0x01 sets status bit 7; any other value leaves the status unchanged. The device then returns to array-read.
- R9: After command 0x90, a read at word index 0 returns the manufacturer code (0x0089), index 1 returns the device code (0x0018), and any other index returns 0. A write in this state is decoded as a new command.
- R10: After command 0x98, reads return a query byte indexed by the low address byte shifted right by one. Indexes 0 to 9 hold 0x51, 0x52, 0x59, 0x01, log2 of the array size (8), log2 of the buffer bytes (5), sector bytes low (0x20), sector bytes high (0x00), sector count minus one high (0x00) and low (0x07). Index 10 and above read 0. Only a write of 0xFF leaves this mode; other writes are ignored.
- R11: An unrecognised command in array-read mode returns the device to array-read and leaves the array and status unchanged.
- R12: With `wrEn` low the command state, the array and the status do not change. With `rdEn` low, `rdData` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (8) | Byte address of the access |
| wrData | input | DATA_W (16) | Write data; the low byte is the command code |
| wrEn | input | 1 | Write strobe: one bus write cycle |
| rdEn | input | 1 | Read strobe: one bus read cycle |
| rdData | output | DATA_W (16) | Registered read data, updated when rdEn is sampled |

## Verification
The hardest situation to reach is the last data word of a buffered program and the confirm after it. The count decrement, the switch to the confirm state and the return to array-read all happen on writes that look the same from the bus. The stimulus places a status read between the data words and another one before the confirm, so the reads show which phase the device is in. Sector erase is checked against neighbouring sectors that were programmed first. A sweep erases every sector and reads back every word, which covers the sector address decode completely.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [3:0] {
    ST_ARRAY,
    ST_PROG,
    ST_ERASE,
    ST_LOCK,
    ST_STATUS,
    ST_IDENT,
    ST_QUERY,
    ST_BUFCNT,
    ST_BUFDATA,
    ST_BUFCONF
  } cmdState_t;

  typedef enum logic [1:0] {
    SRC_ARRAY,
    SRC_STATUS,
    SRC_IDENT,
    SRC_QUERY
  } rdSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   wordWr;
    logic   sectErase;
    logic   setReady;
    logic   clrStatus;
    rdSrc_t rdSrc;
  } ctrlStrobe_t;

  localparam logic [7:0] OP_PROG_A   = 8'h10;
  localparam logic [7:0] OP_PROG_B   = 8'h40;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_CLRSTAT  = 8'h50;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_QUERY    = 8'h98;
  localparam logic [7:0] OP_BUFFER   = 8'hE8;
  localparam logic [7:0] OP_ARRAY    = 8'hFF;
  localparam logic [7:0] OP_NOP      = 8'h00;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_LOCKALT  = 8'h01;

endpackage

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [7:0]       cmdByte,
  input  logic [CNT_W-1:0] cntIn,
  output ctrlStrobe_t      strobe,
  output cmdState_t        state,
  output logic [CNT_W-1:0] count
);

  cmdState_t        nextState;
  logic [CNT_W-1:0] nextCount;

  // read source follows the current state only
  always_comb begin
    unique case (state)
      ST_ARRAY, ST_PROG: strobe.rdSrc = SRC_ARRAY;
      ST_IDENT:          strobe.rdSrc = SRC_IDENT;
      ST_QUERY:          strobe.rdSrc = SRC_QUERY;
      default:           strobe.rdSrc = SRC_STATUS;
    endcase
  end

  always_comb begin
    nextState        = state;
    nextCount        = count;
    strobe.wordWr    = 1'b0;
    strobe.sectErase = 1'b0;
    strobe.setReady  = 1'b0;
    strobe.clrStatus = 1'b0;
    if (wrEn) begin
      unique case (state)
        ST_ARRAY, ST_STATUS, ST_IDENT: begin
          unique case (cmdByte)
            OP_PROG_A, OP_PROG_B: nextState = ST_PROG;
            OP_ERASE: begin
              strobe.sectErase = 1'b1;
              strobe.setReady  = 1'b1;
              nextState        = ST_ERASE;
            end
            OP_CLRSTAT: begin
              strobe.clrStatus = 1'b1;
              nextState        = ST_ARRAY;
            end
            OP_LOCK:   nextState = ST_LOCK;
            OP_STATUS: nextState = ST_STATUS;
            OP_IDENT:  nextState = ST_IDENT;
            OP_QUERY:  nextState = ST_QUERY;
            OP_BUFFER: begin
              strobe.setReady = 1'b1;
              nextState       = ST_BUFCNT;
            end
            default:   nextState = ST_ARRAY;
          endcase
        end
        ST_PROG: begin
          strobe.wordWr   = 1'b1;
          strobe.setReady = 1'b1;
          nextState       = ST_ARRAY;
        end
        ST_ERASE: begin
          strobe.setReady = (cmdByte == OP_CONFIRM);
          nextState       = ST_ARRAY;
        end
        ST_LOCK: begin
          strobe.setReady = (cmdByte == OP_CONFIRM) || (cmdByte == OP_LOCKALT);
          nextState       = ST_ARRAY;
        end
        ST_BUFCNT: begin
          nextCount = cntIn;
          nextState = ST_BUFDATA;
        end
        ST_BUFDATA: begin
          strobe.wordWr   = 1'b1;
          strobe.setReady = 1'b1;
          if (count == '0) nextState = ST_BUFCONF;
          else             nextCount = count - 1'b1;
        end
        ST_BUFCONF: begin
          strobe.setReady = (cmdByte == OP_CONFIRM);
          nextState       = ST_ARRAY;
        end
        ST_QUERY: begin
          if (cmdByte == OP_ARRAY) nextState = ST_ARRAY;
        end
        default: nextState = ST_ARRAY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_ARRAY;
      count <= '0;
    end else begin
      state <= nextState;
      count <= nextCount;
    end
  end

endmodule

// File: rtl/nor_cmd_dpath.sv
module nor_cmd_dpath
  import nor_cmd_pkg::*;
#(
  parameter int          DATA_BYTES   = 2,
  parameter int          ARRAY_BYTES  = 256,
  parameter int          SECTOR_BYTES = 32,
  parameter int          BUF_WORDS    = 16,
  parameter bit          BIG_ENDIAN   = 1'b1,
  parameter logic [15:0] ID_MFG       = 16'h0089,
  parameter logic [15:0] ID_DEV       = 16'h0018,
  localparam int         DATA_W       = 8 * DATA_BYTES,
  localparam int         ADDR_W       = $clog2(ARRAY_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  ctrlStrobe_t       strobe,
  output logic [DATA_W-1:0] rdData,
  output logic [7:0]        statusReg
);

  localparam int WSH       = $clog2(DATA_BYTES);
  localparam int SECT_SH   = $clog2(SECTOR_BYTES);
  localparam int NSECT     = ARRAY_BYTES / SECTOR_BYTES;
  localparam int QUERY_LEN = 10;
  localparam logic [15:0] SECT16  = 16'(SECTOR_BYTES);
  localparam logic [15:0] NSECTM1 = 16'(NSECT - 1);
  localparam logic [7:0]  LOG_ARR = 8'($clog2(ARRAY_BYTES));
  localparam logic [7:0]  LOG_BUF = 8'($clog2(BUF_WORDS * DATA_BYTES));

  logic [7:0] mem [ARRAY_BYTES];

  // byte lane of wrData/rdData that maps to byte k of a word
  function automatic int laneOf(input int k);
    return BIG_ENDIAN ? (DATA_BYTES - 1 - k) : k;
  endfunction

  function automatic logic [7:0] queryByte(input logic [7:0] idx);
    unique case (idx)
      8'd0:    return 8'h51;
      8'd1:    return 8'h52;
      8'd2:    return 8'h59;
      8'd3:    return 8'h01;
      8'd4:    return LOG_ARR;
      8'd5:    return LOG_BUF;
      8'd6:    return SECT16[7:0];
      8'd7:    return SECT16[15:8];
      8'd8:    return NSECTM1[15:8];
      8'd9:    return NSECTM1[7:0];
      default: return 8'h00;
    endcase
  endfunction

  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] wordSel;
  logic [ADDR_W-1:0] sectSel;
  logic [7:0]        lowByte;
  logic [7:0]        tblIdx;
  logic [DATA_W-1:0] arrWord;
  logic [15:0]       idWord;
  logic [7:0]        qByte;

  assign baseAddr = addr & ~ADDR_W'(DATA_BYTES - 1);
  assign wordSel  = addr >> WSH;
  assign sectSel  = addr >> SECT_SH;
  assign lowByte  = 8'(addr);
  assign tblIdx   = lowByte >> WSH;

  // storage: erase, program and reset fill
  always_ff @(posedge clk) begin
    for (int i = 0; i < ARRAY_BYTES; i++) begin
      if (rst)
        mem[i] <= 8'hFF;
      else if (strobe.sectErase && (sectSel == ADDR_W'(i >> SECT_SH)))
        mem[i] <= 8'hFF;
      else if (strobe.wordWr && (wordSel == ADDR_W'(i >> WSH)))
        mem[i] <= wrData[8*laneOf(i % DATA_BYTES) +: 8];
    end
  end

  always_comb begin
    arrWord = '0;
    for (int k = 0; k < DATA_BYTES; k++)
      arrWord[8*laneOf(k) +: 8] = mem[baseAddr + ADDR_W'(k)];
  end

  always_comb begin
    unique case (tblIdx)
      8'd0:    idWord = ID_MFG;
      8'd1:    idWord = ID_DEV;
      default: idWord = 16'h0000;
    endcase
  end

  assign qByte = (tblIdx < 8'(QUERY_LEN)) ? queryByte(tblIdx) : 8'h00;

  always_ff @(posedge clk) begin
    if (rst)                  statusReg    <= 8'h00;
    else if (strobe.clrStatus) statusReg   <= 8'h00;
    else if (strobe.setReady)  statusReg[7] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (rdEn) begin
      unique case (strobe.rdSrc)
        SRC_ARRAY:  rdData <= arrWord;
        SRC_STATUS: rdData <= DATA_W'(statusReg);
        SRC_IDENT:  rdData <= DATA_W'(idWord);
        default:    rdData <= DATA_W'(qByte);
      endcase
    end
  end

endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash
  import nor_cmd_pkg::*;
#(
  parameter int          DATA_BYTES   = 2,
  parameter int          ARRAY_BYTES  = 256,
  parameter int          SECTOR_BYTES = 32,
  parameter int          BUF_WORDS    = 16,
  parameter bit          BIG_ENDIAN   = 1'b1,
  parameter logic [15:0] ID_MFG       = 16'h0089,
  parameter logic [15:0] ID_DEV       = 16'h0018,
  localparam int         DATA_W       = 8 * DATA_BYTES,
  localparam int         ADDR_W       = $clog2(ARRAY_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData
);

  localparam int CNT_W = $clog2(BUF_WORDS);

  ctrlStrobe_t      ctrlStrobe;
  cmdState_t        ctrlState;
  logic [CNT_W-1:0] bufCount;
  logic [7:0]       statusNow;

  nor_cmd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .cmdByte (wrData[7:0]),
    .cntIn   (wrData[CNT_W-1:0]),
    .strobe  (ctrlStrobe),
    .state   (ctrlState),
    .count   (bufCount)
  );

  nor_cmd_dpath #(
    .DATA_BYTES   (DATA_BYTES),
    .ARRAY_BYTES  (ARRAY_BYTES),
    .SECTOR_BYTES (SECTOR_BYTES),
    .BUF_WORDS    (BUF_WORDS),
    .BIG_ENDIAN   (BIG_ENDIAN),
    .ID_MFG       (ID_MFG),
    .ID_DEV       (ID_DEV)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .wrData    (wrData),
    .rdEn      (rdEn),
    .strobe    (ctrlStrobe),
    .rdData    (rdData),
    .statusReg (statusNow)
  );

endmodule

// File: rtl/nor_cmd_flash_chk.sv
module nor_cmd_flash_chk
  import nor_cmd_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic              rdEn,
  input logic [7:0]        cmdByte,
  input cmdState_t         state,
  input logic [CNT_W-1:0]  count,
  input ctrlStrobe_t       strobe,
  input logic [7:0]        statusReg,
  input logic [DATA_W-1:0] rdData
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (state == ST_ARRAY && statusReg == 8'h00));

  // R4
  erase_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARRAY && wrEn && cmdByte == OP_ERASE) |=> (state == ST_ERASE && statusReg[7]));

  // R5
  buf_count_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BUFDATA && wrEn && count != '0) |=> (state == ST_BUFDATA && count == $past(count) - 1'b1));

  // R5
  buf_last_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BUFDATA && wrEn && count == '0) |=> (state == ST_BUFCONF));

  // R6
  clear_status_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARRAY && wrEn && cmdByte == OP_CLRSTAT) |=> (state == ST_ARRAY && statusReg == 8'h00));

  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.wordWr, strobe.sectErase}));

  // R12
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> ($stable(state) && $stable(statusReg)));

  // R12
  hold_read_chk: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> $stable(rdData));

endmodule

bind nor_cmd_flash nor_cmd_flash_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .cmdByte   (wrData[7:0]),
  .state     (ctrlState),
  .count     (bufCount),
  .strobe    (ctrlStrobe),
  .statusReg (statusNow),
  .rdData    (rdData)
);

// File: tb/test_nor_cmd_flash.sv
module test_nor_cmd_flash;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [15:0] rdData;

  int    nChecks = 0;
  int    nFails  = 0;
  string curReq  = "R1";
  bit    started = 1'b0;

  always #4 clk = ~clk;

  nor_cmd_flash i_nor_cmd_flash (
    .clk(clk), .rst(rst), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData)
  );

  // ---------------- behavioural reference ----------------
  localparam int M_ARRAY = 0, M_PROG = 1, M_ERASE = 2, M_LOCK = 3, M_STAT = 4,
                 M_ID = 5, M_QRY = 6, M_BCNT = 7, M_BDAT = 8, M_BCONF = 9;
  int refMem [256];
  int refMode = M_ARRAY;
  int refStat = 0;
  int refCnt  = 0;
  int expRd   = 0;

  function automatic int refQuery(int i);
    int tbl [10] = '{'h51, 'h52, 'h59, 'h01, 8, 5, 'h20, 0, 0, 7};
    if (i < 10) return tbl[i];
    return 0;
  endfunction

  function automatic int refRead(int a);
    int b = a & 'hFE;
    int i = (a & 'hFF) >> 1;
    case (refMode)
      M_ARRAY, M_PROG: return (refMem[b] << 8) | refMem[b+1];
      M_ID:  return (i == 0) ? 'h0089 : (i == 1) ? 'h0018 : 0;
      M_QRY: return refQuery(i);
      default: return refStat;
    endcase
  endfunction

  task automatic refStore(int a, int d);
    int b = a & 'hFE;
    refMem[b]   = (d >> 8) & 'hFF;
    refMem[b+1] = d & 'hFF;
  endtask

  task automatic refWrite(int a, int d);
    int c = d & 'hFF;
    case (refMode)
      M_ARRAY, M_STAT, M_ID: begin
        if (c == 'h10 || c == 'h40) refMode = M_PROG;
        else if (c == 'h20) begin
          for (int j = 0; j < 32; j++) refMem[(a & 'hE0) + j] = 'hFF;
          refStat = refStat | 'h80;
          refMode = M_ERASE;
        end
        else if (c == 'h50) begin refStat = 0; refMode = M_ARRAY; end
        else if (c == 'h60) refMode = M_LOCK;
        else if (c == 'h70) refMode = M_STAT;
        else if (c == 'h90) refMode = M_ID;
        else if (c == 'h98) refMode = M_QRY;
        else if (c == 'hE8) begin refStat = refStat | 'h80; refMode = M_BCNT; end
        else refMode = M_ARRAY;
      end
      M_PROG: begin refStore(a, d); refStat = refStat | 'h80; refMode = M_ARRAY; end
      M_ERASE: begin if (c == 'hD0) refStat = refStat | 'h80; refMode = M_ARRAY; end
      M_LOCK: begin
        if (c == 'hD0 || c == 'h01) refStat = refStat | 'h80;
        refMode = M_ARRAY;
      end
      M_BCNT: begin refCnt = d & 'hF; refMode = M_BDAT; end
      M_BDAT: begin
        refStore(a, d);
        refStat = refStat | 'h80;
        if (refCnt == 0) refMode = M_BCONF;
        else refCnt = refCnt - 1;
      end
      M_BCONF: begin if (c == 'hD0) refStat = refStat | 'h80; refMode = M_ARRAY; end
      M_QRY: if (c == 'hFF) refMode = M_ARRAY;
      default: refMode = M_ARRAY;
    endcase
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < 256; j++) refMem[j] = 'hFF;
      refMode = M_ARRAY;
      refStat = 0;
      refCnt  = 0;
      expRd   = 0;
      started = 1'b1;
    end else begin
      if (rdEn) expRd = refRead(int'(addr));
      if (wrEn) refWrite(int'(addr), int'(wrData));
    end
  end

  // ---------------- checking ----------------
  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %04h expected %04h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (started && !rst) check(curReq, int'(rdData), expRd);
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    addr = 8'(a); wrData = 16'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdExpect(int a, int exp);
    @(negedge clk);
    addr = 8'(a); rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    check(curReq, int'(rdData), exp);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    curReq = "R1";
    rdExpect(0, 'hFFFF);
    rdExpect(254, 'hFFFF);
    wr(0, 'h70);
    rdExpect(0, 'h0000);
    wr(0, 'hFF);

    curReq = "R3";
    wr(0, 'h40);  wr(4, 'h1234);
    rdExpect(4, 'h1234);
    wr(0, 'h10);  wr(6, 'hABCD);
    rdExpect(6, 'hABCD);

    curReq = "R2";
    rdExpect(5, 'h1234);
    rdExpect(7, 'hABCD);

    curReq = "R7";
    wr(0, 'h70);
    rdExpect(0, 'h0080);
    rdExpect(40, 'h0080);

    curReq = "R9";
    wr(0, 'h90);
    rdExpect(0, 'h0089);
    rdExpect(2, 'h0018);
    rdExpect(4, 'h0000);
    rdExpect(3, 'h0018);
    wr(0, 'hFF);

    curReq = "R6";
    wr(0, 'h50);
    wr(0, 'h70);
    rdExpect(0, 'h0000);
    wr(0, 'h00);
    rdExpect(4, 'h1234);

    curReq = "R4";
    wr(0, 'h40); wr(32, 'h1111);
    wr(0, 'h40); wr(62, 'h2222);
    wr(0, 'h40); wr(64, 'h3333);
    wr(0, 'h50);
    wr(40, 'h20);
    rdExpect(40, 'h0080);
    wr(40, 'hD0);
    rdExpect(32, 'hFFFF);
    rdExpect(62, 'hFFFF);
    rdExpect(64, 'h3333);
    rdExpect(4, 'h1234);
    wr(0, 'h40); wr(96, 'h5555);
    wr(100, 'h20);
    wr(100, 'h33);
    rdExpect(96, 'hFFFF);

    curReq = "R8";
    wr(0, 'h50);
    wr(0, 'h60);
    rdExpect(0, 'h0000);
    wr(0, 'h01);
    wr(0, 'h70);
    rdExpect(0, 'h0080);
    wr(0, 'h50);
    wr(0, 'h60);
    wr(0, 'h44);
    wr(0, 'h70);
    rdExpect(0, 'h0000);
    wr(0, 'h60);
    wr(0, 'hD0);
    wr(0, 'h70);
    rdExpect(0, 'h0080);
    wr(0, 'hFF);

    curReq = "R5";
    wr(0, 'h50);
    wr(128, 'hE8);
    rdExpect(128, 'h0080);
    wr(128, 3);
    wr(128, 'hA000);
    rdExpect(130, 'h0080);
    wr(130, 'hA001);
    wr(132, 'hA002);
    wr(134, 'hA003);
    rdExpect(0, 'h0080);
    wr(0, 'hD0);
    rdExpect(128, 'hA000);
    rdExpect(130, 'hA001);
    rdExpect(132, 'hA002);
    rdExpect(134, 'hA003);
    rdExpect(136, 'hFFFF);

    curReq = "R10";
    wr(0, 'h98);
    rdExpect(0, 'h0051);
    rdExpect(2, 'h0052);
    rdExpect(4, 'h0059);
    rdExpect(8, 'h0008);
    rdExpect(10, 'h0005);
    rdExpect(12, 'h0020);
    rdExpect(18, 'h0007);
    rdExpect(20, 'h0000);
    wr(0, 'h55);
    rdExpect(0, 'h0051);
    wr(0, 'hFF);
    rdExpect(4, 'h1234);

    curReq = "R11";
    wr(0, 'h50);
    wr(0, 'h33);
    rdExpect(4, 'h1234);
    wr(0, 'h70);
    rdExpect(0, 'h0000);
    wr(0, 'hFF);

    curReq = "R12";
    @(negedge clk);
    addr = 8'd4; wrData = 16'h0020;
    repeat (4) @(negedge clk);
    rdExpect(4, 'h1234);
    addr = 8'd6;
    repeat (3) @(negedge clk);
    check("R12", int'(rdData), 'h1234);

    curReq = "R4";
    for (int s = 0; s < 8; s++) begin
      wr(s * 32, 'h40); wr(s * 32 + 2, 'h0F00 + s);
    end
    for (int s = 0; s < 8; s++) begin
      wr(s * 32, 'h20); wr(s * 32, 'hD0);
    end
    for (int w = 0; w < 128; w++) rdExpect(w * 2, 'hFFFF);

    curReq = "R1";
    wr(0, 'h40); wr(10, 'h7777);
    wr(0, 'h70);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1", int'(rdData), 0);
    rdExpect(10, 'hFFFF);
    wr(0, 'h70);
    rdExpect(0, 'h0000);

    finishRun();
  end

endmodule